// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the timing skeleton of a progressive raster display from a single pixel clock: a horizontal sync, a vertical sync, a data-enable strobe, the current pixel and line position, and a one-cycle pulse that marks the first pixel of each frame. It fetches no pixels and makes no clocks. It only tells downstream logic where the scan is and when the panel expects visible data.

The mode is described on static configuration inputs. Per axis these are the visible size, the front porch (blank interval after the visible region), the sync length and the back porch (blank interval before the next visible region). Each sync has its own polarity, and a doublescan option shows every visible line twice. The block waits after reset until `start` is seen. It then scans without stopping. It takes a new copy of the configuration at every frame boundary, so a change applied mid-frame shows up cleanly from the next frame.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset and until `start` is sampled high, de=0, frame_start=0, x=0, y=0, hsync=1 and vsync=1.
- R2: Once running, x advances by one each clock from 0 to Htot-1 and then returns to 0, where Htot = h_active + h_front + h_sync + h_back. y advances by one when x wraps, from 0 to Vtot-1 with Vtot = v_active + v_front + v_sync + v_back, then returns to 0.
- R3: The horizontal sync is asserted for x in [h_active+h_front, h_active+h_front+h_sync). With h_pol=1 the asserted level is 1 and the idle level is 0. With h_pol=0 the asserted level is 0 and the idle level is 1.
- R4: The vertical sync is asserted for y in [v_active+v_front, v_active+v_front+v_sync), for whole lines, changing together with y at x=0. v_pol selects the levels in the same way as h_pol does for the horizontal sync.
- R5: de is 1 exactly when x < h_active and y < v_active. It is never 1 while hsync is at its asserted level.
- R6: frame_start is 1 for exactly one clock, the clock where x=0 and y=0, on the first copy of that line.
- R7: With dscan=1, each line with y < v_active is emitted for two consecutive line periods with the same y. Blanking lines are emitted once, and frame_start does not repeat on the second copy.
- R8: When `start` is sampled high while idle, the clock that follows that edge shows x=0, y=0, frame_start=1.
- R9: `start` has no effect while scanning is in progress: the output sequence continues unchanged.
- R10: Configuration inputs are captured when `start` is accepted and again on the clock that ends the last pixel of each frame. Changes between those points first affect the following frame.
- R11: With the default 12-bit widths, the block runs a 1366x768 mode (58/58/58 pixels, 4/4/4 lines, hsync asserted high) and a 1920x1080 mode (25/25/25 pixels, 2/2/2 lines).
- R12: A front or back porch of zero is legal: the sync then directly follows the visible region, or the next line directly follows the sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin scanning at the top-left corner (accepted only while idle) |
| cfg_h_active | input | HW | Visible pixels per line |
| cfg_h_front | input | HW | Horizontal front porch, pixels |
| cfg_h_sync | input | HW | Horizontal sync length, pixels |
| cfg_h_back | input | HW | Horizontal back porch, pixels |
| cfg_v_active | input | VW | Visible lines per frame |
| cfg_v_front | input | VW | Vertical front porch, lines |
| cfg_v_sync | input | VW | Vertical sync length, lines |
| cfg_v_back | input | VW | Vertical back porch, lines |
| cfg_h_pol | input | 1 | 1: hsync asserted high, 0: asserted low |
| cfg_v_pol | input | 1 | 1: vsync asserted high, 0: asserted low |
| cfg_dscan | input | 1 | Show each visible line twice |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Visible-data strobe |
| x | output | HW | Pixel position within the line |
| y | output | VW | Line position within the frame |
| frame_start | output | 1 | One-clock pulse at the first pixel of a frame |

## Verification
Small modes are scanned over two full frames. One has both polarities differing and no doublescan. The other flips the polarities and turns doublescan on. Together they separate polarity errors from region-boundary errors and show whether the repeat happens only in the visible band. A mode with zero porches checks the boundaries where sync meets the visible region and the wrap. A run that changes the configuration and pulses `start` mid-frame shows that the new mode waits for the frame boundary and that the pulse is ignored. The two large panel modes are run over their first lines to confirm that the wide totals fit the counters.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [HW-1:0] cfg_h_active,
  input  logic [HW-1:0] cfg_h_front,
  input  logic [HW-1:0] cfg_h_sync,
  input  logic [HW-1:0] cfg_h_back,
  input  logic [VW-1:0] cfg_v_active,
  input  logic [VW-1:0] cfg_v_front,
  input  logic [VW-1:0] cfg_v_sync,
  input  logic [VW-1:0] cfg_v_back,
  input  logic          cfg_h_pol,
  input  logic          cfg_v_pol,
  input  logic          cfg_dscan,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [HW-1:0] x,
  output logic [VW-1:0] y,
  output logic          frame_start
);
  localparam int HS = HW + 2;
  localparam int VS = VW + 2;

  logic          running, rep;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [HW-1:0] ha_r, hf_r, hs_r, hb_r;
  logic [VW-1:0] va_r, vf_r, vs_r, vb_r;
  logic          hpol_r, vpol_r, dscan_r;

  logic [HS-1:0] h_sync_beg, h_sync_end, htot;
  logic [VS-1:0] v_sync_beg, v_sync_end, vtot;
  logic          line_end, frame_end, hold_line, v_vis, h_vis, h_on, v_on, load;

  assign h_sync_beg = HS'(ha_r) + HS'(hf_r);
  assign h_sync_end = h_sync_beg + HS'(hs_r);
  assign htot       = h_sync_end + HS'(hb_r);
  assign v_sync_beg = VS'(va_r) + VS'(vf_r);
  assign v_sync_end = v_sync_beg + VS'(vs_r);
  assign vtot       = v_sync_end + VS'(vb_r);

  assign h_vis     = HS'(hcnt) < HS'(ha_r);
  assign v_vis     = VS'(vcnt) < VS'(va_r);
  assign line_end  = HS'(hcnt) == htot - HS'(1);
  assign hold_line = dscan_r && v_vis && !rep;
  assign frame_end = line_end && !hold_line && (VS'(vcnt) == vtot - VS'(1));
  assign load      = running ? frame_end : start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      rep     <= 1'b0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        rep     <= 1'b0;
        hcnt    <= '0;
        vcnt    <= '0;
      end
    end else if (line_end) begin
      hcnt <= '0;
      if (hold_line) begin
        rep <= 1'b1;
      end else begin
        rep  <= 1'b0;
        vcnt <= frame_end ? '0 : vcnt + VW'(1);
      end
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ha_r, hf_r, hs_r, hb_r} <= '0;
      {va_r, vf_r, vs_r, vb_r} <= '0;
      {hpol_r, vpol_r, dscan_r} <= '0;
    end else if (load) begin
      {ha_r, hf_r, hs_r, hb_r} <= {cfg_h_active, cfg_h_front, cfg_h_sync, cfg_h_back};
      {va_r, vf_r, vs_r, vb_r} <= {cfg_v_active, cfg_v_front, cfg_v_sync, cfg_v_back};
      {hpol_r, vpol_r, dscan_r} <= {cfg_h_pol, cfg_v_pol, cfg_dscan};
    end
  end

  assign h_on = running && (HS'(hcnt) >= h_sync_beg) && (HS'(hcnt) < h_sync_end);
  assign v_on = running && (VS'(vcnt) >= v_sync_beg) && (VS'(vcnt) < v_sync_end);

  assign hsync       = h_on ~^ hpol_r;
  assign vsync       = v_on ~^ vpol_r;
  assign de          = running && h_vis && v_vis;
  assign x           = hcnt;
  assign y           = vcnt;
  assign frame_start = running && hcnt == '0 && vcnt == '0 && !rep;

  // R1
  idle_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (x == '0 && y == '0 && !de));

  // R2
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && !line_end |=> x == $past(x) + HW'(1));

  // R2
  y_hold_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && !line_end |=> $stable(y));

  // R5
  de_sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> hsync != hpol_r);

  // R6
  fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && htot > HS'(1) |=> !frame_start);

  // R7
  dscan_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && line_end && hold_line |=> y == $past(y) && !frame_start);

  // R9
  keep_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && !frame_end |=> $stable(ha_r) && $stable(va_r) && $stable(hpol_r)
                              && $stable(vpol_r) && $stable(dscan_r) && $stable(htot));
endmodule

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
  localparam int CLK_NS = 10;
  localparam int HW = 12;
  localparam int VW = 12;

  typedef struct {
    int ha, hf, hs, hb, va, vf, vs, vb;
    bit hp, vp, ds;
  } mode_t;

  typedef struct {
    bit hs, vs, de, fs;
    int x, y;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [HW-1:0] h_act, h_fp, h_sw, h_bp;
  logic [VW-1:0] v_act, v_fp, v_sw, v_bp;
  logic h_pol, v_pol, dscan;
  logic hsync, vsync, de, frame_start;
  logic [HW-1:0] x;
  logic [VW-1:0] y;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  raster_timing_gen #(.HW(HW), .VW(VW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_h_active(h_act), .cfg_h_front(h_fp), .cfg_h_sync(h_sw), .cfg_h_back(h_bp),
    .cfg_v_active(v_act), .cfg_v_front(v_fp), .cfg_v_sync(v_sw), .cfg_v_back(v_bp),
    .cfg_h_pol(h_pol), .cfg_v_pol(v_pol), .cfg_dscan(dscan),
    .hsync(hsync), .vsync(vsync), .de(de), .x(x), .y(y), .frame_start(frame_start)
  );

  task automatic apply(input mode_t m);
    h_act = HW'(m.ha); h_fp = HW'(m.hf); h_sw = HW'(m.hs); h_bp = HW'(m.hb);
    v_act = VW'(m.va); v_fp = VW'(m.vf); v_sw = VW'(m.vs); v_bp = VW'(m.vb);
    h_pol = m.hp; v_pol = m.vp; dscan = m.ds;
  endtask

  // expected sequence from R2..R7
  task automatic push_frame(input mode_t m, input int limit);
    int n = 0;
    int htot = m.ha + m.hf + m.hs + m.hb;
    int vtot = m.va + m.vf + m.vs + m.vb;
    for (int l = 0; l < vtot; l++) begin
      int reps = (m.ds && l < m.va) ? 2 : 1;
      bit von = (l >= m.va + m.vf) && (l < m.va + m.vf + m.vs);
      for (int r = 0; r < reps; r++) begin
        for (int p = 0; p < htot; p++) begin
          exp_t e;
          bit hon = (p >= m.ha + m.hf) && (p < m.ha + m.hf + m.hs);
          if (n >= limit) return;
          e.hs = m.hp ? hon : !hon;
          e.vs = m.vp ? von : !von;
          e.de = (p < m.ha) && (l < m.va);
          e.fs = (p == 0) && (l == 0) && (r == 0);
          e.x = p;
          e.y = l;
          q.push_back(e);
          n++;
        end
      end
    end
  endtask

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (armed && q.size() > 0) begin
      exp_t e;
      string req;
      e = q.pop_front();
      checks++;
      if (hsync !== e.hs || vsync !== e.vs || de !== e.de || frame_start !== e.fs ||
          int'(x) != e.x || int'(y) != e.y) begin
        errors++;
        if (int'(x) != e.x || int'(y) != e.y) req = "R2";
        else if (hsync !== e.hs) req = "R3";
        else if (vsync !== e.vs) req = "R4";
        else if (de !== e.de) req = "R5";
        else req = "R6";
        $display("FAIL %s actual x=%0d y=%0d hs=%b vs=%b de=%b fs=%b expected x=%0d y=%0d hs=%b vs=%b de=%b fs=%b",
                 req, x, y, hsync, vsync, de, frame_start, e.x, e.y, e.hs, e.vs, e.de, e.fs);
      end
    end
  end

  task automatic do_reset;
    armed = 1'b0;
    start = 1'b0;
    q.delete();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // R8: first pixel on the clock after start is sampled
  task automatic launch;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    armed = 1'b1;
  endtask

  task automatic drain;
    while (q.size() != 0) @(posedge clk);
    armed = 1'b0;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    mode_t ma, mb, mc, mz, m1366, m1920;
    ma    = '{8, 2, 3, 1, 4, 1, 2, 2, 1'b1, 1'b0, 1'b0};
    mb    = '{6, 1, 2, 2, 3, 2, 1, 2, 1'b0, 1'b1, 1'b1};
    mc    = '{5, 3, 1, 2, 3, 1, 1, 1, 1'b0, 1'b0, 1'b0};
    mz    = '{4, 0, 2, 0, 2, 0, 1, 0, 1'b1, 1'b1, 1'b0};
    m1366 = '{1366, 58, 58, 58, 768, 4, 4, 4, 1'b1, 1'b0, 1'b0};
    m1920 = '{1920, 25, 25, 25, 1080, 2, 2, 2, 1'b0, 1'b0, 1'b0};
    apply(ma);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 de", int'(de), 0);
    chk("R1 frame_start", int'(frame_start), 0);
    chk("R1 x", int'(x), 0);
    chk("R1 y", int'(y), 0);
    chk("R1 hsync", int'(hsync), 1);
    chk("R1 vsync", int'(vsync), 1);
    repeat (6) @(negedge clk);
    chk("R1 idle x", int'(x), 0);
    chk("R1 idle de", int'(de), 0);

    // R2 R3 R4 R5 R6 R8: two frames, no doublescan
    push_frame(ma, 1 << 30);
    push_frame(ma, 1 << 30);
    launch();
    drain();

    // R7 doublescan with opposite polarities
    do_reset();
    apply(mb);
    push_frame(mb, 1 << 30);
    push_frame(mb, 1 << 30);
    launch();
    drain();

    // R12 zero porches
    do_reset();
    apply(mz);
    push_frame(mz, 1 << 30);
    push_frame(mz, 1 << 30);
    launch();
    drain();

    // R10 mid-frame change, R9 start while running
    do_reset();
    apply(ma);
    push_frame(ma, 1 << 30);
    push_frame(mc, 1 << 30);
    launch();
    repeat (30) @(negedge clk);
    apply(mc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();

    // R11 large panel modes, first lines
    do_reset();
    apply(m1366);
    push_frame(m1366, 3 * (1366 + 174));
    launch();
    drain();

    do_reset();
    apply(m1920);
    push_frame(m1920, 3 * (1920 + 75));
    launch();
    drain();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule